// File: doc/BRIEF.md
# Adaptive Power-Gating Controller

This block decides, cycle by cycle, when the supply of one functional unit (a vector lane, for instance) is cut and when it is restored. It watches a per-cycle busy/request line. Once the unit has been idle for a programmable number of consecutive cycles, it raises a sleep line to the sleep transistors. When a request arrives during sleep, it lowers the sleep line. It then holds the ready line low for a fixed wakeup delay, and any request in that window stalls. A branch-mispredict pulse can be chosen as a second way to send the unit to sleep at once.

Two policies run on top of the basic gating. Both act on a boundary pulse that the surrounding logic supplies once per monitoring interval.

The first policy tunes the idle-detect length. It counts the busy cycles in each interval. A busy interval doubles the idle-detect length, which means fewer gating events. A quiet interval halves it, which means more cycles spent off. The length always stays between programmable power-of-two bounds.

The second policy scores every sleep episode. The score is the number of cycles spent off, less a breakeven cost. The scores are summed per interval. Gating is allowed in the next interval only if that sum shows no net loss.

Top module: `pg_ctrl`

## Requirements
- R1: Reset is synchronous and active high. While reset is asserted, the block leaves sleep_o at 0 and ready_o at 1, enables gating, and sets the idle exponent to min_exp_i. After reset is released, sleep_o rises after exactly 2^min_exp_i idle cycles.
- R2: Gating must be enabled and the unit powered. The idle-detect length is 2^e cycles, where e is the current idle exponent. sleep_o goes to 1 in the cycle after the 2^e-th consecutive cycle with busy_i=0. Any cycle with busy_i=1 restarts the count from zero.
- R3: In sleep, a cycle with busy_i=1 drops sleep_o in the next cycle. ready_o then stays 0 for exactly WAKE_DLY cycles and rises afterwards. The value of busy_i during those cycles has no effect.
- R4: With mp_sel_i=1, a cycle that has mispredict_i=1 and busy_i=0 sends the powered unit to sleep in the next cycle. Gating must be enabled for this. With mp_sel_i=0, or with busy_i=1, the pulse has no effect.
- R5: Busy cycles are counted over a monitoring interval, including the cycle in which tick_i=1, and the count saturates. If the count is at least hi_thr_i, e goes up by one, capped at max_exp_i. Otherwise, if the count is below lo_thr_i, e goes down by one, floored at min_exp_i. Otherwise e is unchanged. The new value takes effect from the cycle after the tick, and e changes at no other time.
- R6: Each sleep episode scores (number of cycles sleep_o was 1) minus BREAKEVEN when it ends on a request. The scores are summed into a signed SCORE_W-bit total that saturates. An episode ending in the tick cycle counts toward the interval that closes. At the tick, gating is enabled for the next interval if the total is at least 0 and disabled otherwise, and the total is cleared.
- R7: While gating is disabled, neither the idle count nor a mispredict pulse makes sleep_o rise. A sleep already in progress lasts until a request.
- R8: sleep_o and ready_o are never both 1, and both come from registers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| busy_i | input | 1 | Unit is used or requested this cycle |
| mispredict_i | input | 1 | Branch-mispredict pulse |
| mp_sel_i | input | 1 | Selects the mispredict pulse as an immediate sleep trigger |
| tick_i | input | 1 | Last cycle of a monitoring interval |
| hi_thr_i | input | BUSY_W | Busy count at or above which the idle length grows |
| lo_thr_i | input | BUSY_W | Busy count below which the idle length shrinks |
| min_exp_i | input | EXP_W | Lowest idle exponent (at most IDLE_W) |
| max_exp_i | input | EXP_W | Highest idle exponent (at most IDLE_W) |
| sleep_o | output | 1 | Drives the sleep transistors off the supply |
| ready_o | output | 1 | Unit is powered and accepts work |

## Verification
The hardest state to reach from the ports is an interval with gating disabled. Reaching it takes an interval whose episode scores add up to a net loss. The stimulus builds one from sleeps that are woken one cycle after they begin, each costing BREAKEVEN-1. It then confirms that long idle stretches and mispredict pulses cannot cause a sleep. A following empty interval must enable gating again. The random phase varies the busy density from block to block, so the idle exponent is pushed against both of its bounds. The same phase drives enough short and long episodes that the score total saturates at both ends, and a cycle-level model follows each case.

// File: rtl/pg_pkg.sv
package pg_pkg;
  typedef enum logic [1:0] {
    ST_ON    = 2'd0,
    ST_IDLE  = 2'd1,
    ST_SLEEP = 2'd2,
    ST_WAKE  = 2'd3
  } pg_state_e;
endpackage

// File: rtl/pg_fsm.sv
module pg_fsm
  import pg_pkg::*;
#(
  parameter int IDLE_W   = 12,
  parameter int WAKE_DLY = 4,
  parameter int OFF_W    = 10
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              busy,
  input  logic              mp_pulse,
  input  logic              mp_sel,
  input  logic              gate_en,
  input  logic [IDLE_W:0]   idle_thr,
  output logic              sleep_o,
  output logic              ready_o,
  output logic              ev_valid,
  output logic [OFF_W-1:0]  ev_off
);
  localparam int WK_W = $clog2(WAKE_DLY) + 1;

  pg_state_e        st;
  logic [IDLE_W:0]  idle_cnt;
  logic [IDLE_W:0]  idle_nxt;
  logic [WK_W-1:0]  wk_cnt;
  logic [OFF_W-1:0] off_cnt;
  logic             go_sleep;

  always_comb begin
    idle_nxt = (idle_cnt == '1) ? idle_cnt : idle_cnt + 1'b1;
    go_sleep = gate_en && ((mp_sel && mp_pulse) || (idle_nxt >= idle_thr));
    ev_valid = (st == ST_SLEEP) && busy;
    ev_off   = off_cnt;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st       <= ST_ON;
      idle_cnt <= '0;
      wk_cnt   <= '0;
      off_cnt  <= '0;
      sleep_o  <= 1'b0;
      ready_o  <= 1'b1;
    end else begin
      case (st)
        ST_ON, ST_IDLE: begin
          if (busy) begin
            st       <= ST_ON;
            idle_cnt <= '0;
          end else if (go_sleep) begin
            st       <= ST_SLEEP;
            sleep_o  <= 1'b1;
            ready_o  <= 1'b0;
            off_cnt  <= OFF_W'(1);
            idle_cnt <= '0;
          end else begin
            st       <= ST_IDLE;
            idle_cnt <= idle_nxt;
          end
        end
        ST_SLEEP: begin
          if (busy) begin
            st      <= ST_WAKE;
            sleep_o <= 1'b0;
            wk_cnt  <= '0;
          end else if (off_cnt != '1) begin
            off_cnt <= off_cnt + 1'b1;
          end
        end
        default: begin
          if (wk_cnt == WK_W'(WAKE_DLY - 1)) begin
            st       <= ST_ON;
            ready_o  <= 1'b1;
            idle_cnt <= '0;
          end else begin
            wk_cnt <= wk_cnt + 1'b1;
          end
        end
      endcase
    end
  end
endmodule

// File: rtl/pg_adapt.sv
module pg_adapt #(
  parameter int IDLE_W = 12,
  parameter int EXP_W  = 4,
  parameter int BUSY_W = 10
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              busy,
  input  logic              tick,
  input  logic [BUSY_W-1:0] hi_thr,
  input  logic [BUSY_W-1:0] lo_thr,
  input  logic [EXP_W-1:0]  min_exp,
  input  logic [EXP_W-1:0]  max_exp,
  output logic [EXP_W-1:0]  idle_exp,
  output logic [IDLE_W:0]   idle_thr
);
  logic [BUSY_W-1:0] busy_cnt;
  logic [BUSY_W-1:0] busy_sum;

  always_comb begin
    busy_sum = (busy_cnt == '1) ? busy_cnt : busy_cnt + BUSY_W'(busy);
    idle_thr = (IDLE_W+1)'(1) << idle_exp;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_cnt <= '0;
      idle_exp <= min_exp;
    end else if (tick) begin
      busy_cnt <= '0;
      if (busy_sum >= hi_thr) begin
        if (idle_exp < max_exp) idle_exp <= idle_exp + 1'b1;
      end else if (busy_sum < lo_thr) begin
        if (idle_exp > min_exp) idle_exp <= idle_exp - 1'b1;
      end
    end else begin
      busy_cnt <= busy_sum;
    end
  end
endmodule

// File: rtl/pg_monitor.sv
module pg_monitor #(
  parameter int OFF_W     = 10,
  parameter int SCORE_W   = 8,
  parameter int BREAKEVEN = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick,
  input  logic             ev_valid,
  input  logic [OFF_W-1:0] ev_off,
  output logic             gate_en
);
  localparam int WW = SCORE_W + OFF_W + 2;
  localparam logic signed [WW-1:0] S_MAX = WW'(2**(SCORE_W-1) - 1);
  localparam logic signed [WW-1:0] S_MIN = -S_MAX - 1;

  logic signed [SCORE_W-1:0] score;
  logic signed [WW-1:0]      delta;
  logic signed [WW-1:0]      sum;
  logic signed [SCORE_W-1:0] clamped;

  always_comb begin
    delta = ev_valid ? ($signed({{(WW-OFF_W){1'b0}}, ev_off}) - $signed(WW'(BREAKEVEN)))
                     : '0;
    sum   = WW'(score) + delta;
    if (sum > S_MAX)      clamped = S_MAX[SCORE_W-1:0];
    else if (sum < S_MIN) clamped = S_MIN[SCORE_W-1:0];
    else                  clamped = sum[SCORE_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      score   <= '0;
      gate_en <= 1'b1;
    end else if (tick) begin
      score   <= '0;
      gate_en <= !clamped[SCORE_W-1];
    end else begin
      score <= clamped;
    end
  end
endmodule

// File: rtl/pg_ctrl.sv
module pg_ctrl #(
  parameter int IDLE_W    = 12,
  parameter int EXP_W     = $clog2(IDLE_W + 1),
  parameter int WAKE_DLY  = 4,
  parameter int BREAKEVEN = 8,
  parameter int OFF_W     = 10,
  parameter int BUSY_W    = 10,
  parameter int SCORE_W   = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              busy_i,
  input  logic              mispredict_i,
  input  logic              mp_sel_i,
  input  logic              tick_i,
  input  logic [BUSY_W-1:0] hi_thr_i,
  input  logic [BUSY_W-1:0] lo_thr_i,
  input  logic [EXP_W-1:0]  min_exp_i,
  input  logic [EXP_W-1:0]  max_exp_i,
  output logic              sleep_o,
  output logic              ready_o
);
  logic             gate_en_w;
  logic [EXP_W-1:0] idle_exp_w;
  logic [IDLE_W:0]  idle_thr_w;
  logic             ev_valid_w;
  logic [OFF_W-1:0] ev_off_w;

  pg_fsm #(.IDLE_W(IDLE_W), .WAKE_DLY(WAKE_DLY), .OFF_W(OFF_W)) u_fsm (
    .clk(clk), .rst(rst), .busy(busy_i), .mp_pulse(mispredict_i), .mp_sel(mp_sel_i),
    .gate_en(gate_en_w), .idle_thr(idle_thr_w), .sleep_o(sleep_o), .ready_o(ready_o),
    .ev_valid(ev_valid_w), .ev_off(ev_off_w)
  );

  pg_adapt #(.IDLE_W(IDLE_W), .EXP_W(EXP_W), .BUSY_W(BUSY_W)) u_adapt (
    .clk(clk), .rst(rst), .busy(busy_i), .tick(tick_i), .hi_thr(hi_thr_i),
    .lo_thr(lo_thr_i), .min_exp(min_exp_i), .max_exp(max_exp_i),
    .idle_exp(idle_exp_w), .idle_thr(idle_thr_w)
  );

  pg_monitor #(.OFF_W(OFF_W), .SCORE_W(SCORE_W), .BREAKEVEN(BREAKEVEN)) u_mon (
    .clk(clk), .rst(rst), .tick(tick_i), .ev_valid(ev_valid_w), .ev_off(ev_off_w),
    .gate_en(gate_en_w)
  );
endmodule

// File: rtl/pg_ctrl_chk.sv
module pg_ctrl_chk #(
  parameter int WAKE_DLY = 4,
  parameter int EXP_W    = 4
) (
  input logic             clk,
  input logic             rst,
  input logic             busy_i,
  input logic             tick_i,
  input logic [EXP_W-1:0] min_exp_i,
  input logic [EXP_W-1:0] max_exp_i,
  input logic             sleep_o,
  input logic             ready_o,
  input logic             gate_en,
  input logic [EXP_W-1:0] idle_exp
);
  int wk_run;

  always_ff @(posedge clk) begin
    if (rst) wk_run <= 0;
    else if (!ready_o && !sleep_o) wk_run <= wk_run + 1;
    else wk_run <= 0;
  end

  p_excl_r8: assert property (@(posedge clk) disable iff (rst)
    !(sleep_o && ready_o));

  p_wake_r3: assert property (@(posedge clk) disable iff (rst)
    (sleep_o && busy_i) |=> (!sleep_o && !ready_o));

  p_delay_r3: assert property (@(posedge clk) disable iff (rst)
    $rose(ready_o) |-> (wk_run == WAKE_DLY));

  p_hold_r2: assert property (@(posedge clk) disable iff (rst)
    (sleep_o && !busy_i) |=> sleep_o);

  p_nogate_r7: assert property (@(posedge clk) disable iff (rst)
    (!gate_en && !sleep_o) |=> !sleep_o);

  p_exp_stable_r5: assert property (@(posedge clk) disable iff (rst)
    !tick_i |=> $stable(idle_exp));

  p_exp_bound_r5: assert property (@(posedge clk) disable iff (rst)
    (idle_exp >= min_exp_i) && (idle_exp <= max_exp_i));
endmodule

bind pg_ctrl pg_ctrl_chk #(.WAKE_DLY(WAKE_DLY), .EXP_W(EXP_W)) u_chk (
  .clk(clk), .rst(rst), .busy_i(busy_i), .tick_i(tick_i),
  .min_exp_i(min_exp_i), .max_exp_i(max_exp_i), .sleep_o(sleep_o),
  .ready_o(ready_o), .gate_en(gate_en_w), .idle_exp(idle_exp_w)
);

// File: tb/sim_pg_ctrl.sv
module sim_pg_ctrl;
  localparam int IDLE_W = 8;
  localparam int EXP_W  = 4;
  localparam int WD     = 4;
  localparam int BE     = 8;
  localparam int OFF_W  = 6;
  localparam int BUSY_W = 8;
  localparam int SC_W   = 6;
  localparam int MINE   = 1;
  localparam int MAXE   = 4;

  logic clk = 0, rst = 1, busy = 0, mp = 0, sel = 0, tick = 0;
  logic [BUSY_W-1:0] hi = 20, lo = 4;
  logic sleep_o, ready_o;
  int n_chk = 0, n_bad = 0;

  pg_ctrl #(.IDLE_W(IDLE_W), .EXP_W(EXP_W), .WAKE_DLY(WD), .BREAKEVEN(BE),
            .OFF_W(OFF_W), .BUSY_W(BUSY_W), .SCORE_W(SC_W)) u0 (
    .clk(clk), .rst(rst), .busy_i(busy), .mispredict_i(mp), .mp_sel_i(sel),
    .tick_i(tick), .hi_thr_i(hi), .lo_thr_i(lo), .min_exp_i(EXP_W'(MINE)),
    .max_exp_i(EXP_W'(MAXE)), .sleep_o(sleep_o), .ready_o(ready_o));

  always #4 clk = ~clk;

  // reference model of R1..R7, advanced on each rising edge
  int m_st, m_idle, m_wk, m_off, m_exp, m_bc, m_sc, m_gate, m_sleep, m_ready;
  always @(posedge clk) begin
    int ssum, bsum, thr;
    if (rst) begin
      m_st = 0; m_idle = 0; m_wk = 0; m_off = 0; m_exp = MINE; m_bc = 0;
      m_sc = 0; m_gate = 1; m_sleep = 0; m_ready = 1;
    end else begin
      ssum = m_sc + ((m_st == 1 && busy) ? m_off - BE : 0);
      if (ssum > (1 << (SC_W-1)) - 1) ssum = (1 << (SC_W-1)) - 1;
      if (ssum < -(1 << (SC_W-1))) ssum = -(1 << (SC_W-1));
      bsum = m_bc + int'(busy);
      if (bsum > (1 << BUSY_W) - 1) bsum = (1 << BUSY_W) - 1;
      thr = 1 << m_exp;
      if (m_st == 0) begin
        if (busy) m_idle = 0;
        else if (m_gate != 0 && ((sel && mp) || m_idle + 1 >= thr)) begin
          m_st = 1; m_sleep = 1; m_ready = 0; m_off = 1; m_idle = 0;
        end else m_idle = m_idle + 1;
      end else if (m_st == 1) begin
        if (busy) begin m_st = 2; m_sleep = 0; m_wk = 0; end
        else if (m_off < (1 << OFF_W) - 1) m_off = m_off + 1;
      end else begin
        if (m_wk == WD - 1) begin m_st = 0; m_ready = 1; m_idle = 0; end
        else m_wk = m_wk + 1;
      end
      if (tick) begin
        if (bsum >= int'(hi)) begin if (m_exp < MAXE) m_exp = m_exp + 1; end
        else if (bsum < int'(lo)) begin if (m_exp > MINE) m_exp = m_exp - 1; end
        m_gate = (ssum >= 0) ? 1 : 0; m_sc = 0; m_bc = 0;
      end else begin
        m_sc = ssum; m_bc = bsum;
      end
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic cyc(input logic b, input logic m, input logic t);
    @(negedge clk);
    busy = b; mp = m; tick = t;
    @(posedge clk);
    #1;
    if (!rst) begin
      chk("R2 sleep_o vs model", int'(sleep_o), m_sleep);
      chk("R3 ready_o vs model", int'(ready_o), m_ready);
    end
  endtask

  task automatic idle_until_sleep(output int n);
    n = 0;
    while (!sleep_o && n < 300) begin cyc(0, 0, 0); n++; end
  endtask

  task automatic wake_count(output int k);
    cyc(1, 0, 0);
    chk("R3 sleep drops on request", int'(sleep_o), 0);
    k = 0;
    while (!ready_o && k < 50) begin cyc(1, 0, 0); k++; end
  endtask

  initial begin
    #(8 * 200000);
    n_bad++;
    $display("FAIL watchdog: actual running expected finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    int n, k, seen;
    void'($urandom(32'h1357));
    cyc(0, 0, 0); cyc(0, 0, 0);
    rst = 0;
    chk("R1 reset sleep_o", int'(sleep_o), 0);
    chk("R1 reset ready_o", int'(ready_o), 1);
    idle_until_sleep(n);
    chk("R1 idle length at min exponent", n, 1 << MINE);
    repeat (10) cyc(0, 0, 0);
    wake_count(k);
    chk("R3 wakeup delay", k, WD);
    repeat (20) cyc(1, 0, 0);
    cyc(1, 0, 1);
    idle_until_sleep(n);
    chk("R5 idle length doubled", n, 4);
    wake_count(k);
    cyc(0, 0, 0); cyc(0, 0, 0); cyc(0, 0, 0); cyc(1, 0, 0);
    idle_until_sleep(n);
    chk("R2 busy restarts idle count", n, 4);
    wake_count(k);
    chk("R3 wakeup delay with busy held", k, WD);
    cyc(0, 0, 1);
    sel = 1; seen = 0;
    for (int i = 0; i < 30; i++) begin
      cyc(0, (i % 7) == 3, 0);
      if (sleep_o) seen = 1;
    end
    chk("R7 no sleep while gating disabled", seen, 0);
    cyc(0, 0, 1);
    idle_until_sleep(n);
    chk("R6 gating re-enabled after empty interval", n, 1);
    wake_count(k);
    sel = 0;
    cyc(0, 1, 0);
    chk("R4 mispredict ignored when not selected", int'(sleep_o), 0);
    sel = 1;
    cyc(1, 1, 0);
    chk("R4 mispredict ignored while busy", int'(sleep_o), 0);
    cyc(0, 1, 0);
    chk("R4 mispredict sleeps at once", int'(sleep_o), 1);
    chk("R8 exclusive outputs", int'(sleep_o && ready_o), 0);
    wake_count(k);
    hi = 40; lo = 10;
    for (int blk = 0; blk < 60; blk++) begin
      int prob;
      case ($urandom % 4)
        0: prob = 3;
        1: prob = 25;
        2: prob = 60;
        default: prob = 95;
      endcase
      sel = ($urandom % 2) == 1;
      for (int c = 0; c < 64; c++) begin
        cyc(($urandom % 100) < prob, ($urandom % 100) < 4, c == 63);
        chk("R8 exclusive outputs", int'(sleep_o && ready_o), 0);
      end
    end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule